// File: doc/BRIEF.md
# Graphics Plane Scanout Formatter

This block fetches one graphics plane from memory as packed 32-bit words and turns them into a stream of studio-range YCbCr pixels for a later post-processing stage. A line walker produces word-aligned byte addresses, and it keeps at most one word request outstanding at a time. Each returned word goes into an eight-byte staging buffer. That buffer cuts pixels out of the byte stream in one of three packings, so a 3-byte pixel can span two words. Each cut pixel is widened to 8 bits per channel and passes through a registered colour-conversion stage. That stage has a valid/ready output.

Software loads the plane settings into a shadow copy at any time. The copy becomes live only on a vertical sync pulse, and the same pulse starts a new scan from the first line. Progressive mode walks every line at the stride. Interlaced mode steps two strides per line, and the field flag sampled at the sync pulse selects an even start (the base) or an odd start (base plus one stride).

Top module: `osd_scan_fmt`

## Requirements
- R1: While and just after reset, `mem_req_valid` and `pix_valid` are low, and the live plane is disabled.
- R2: A `cfg_wr` pulse only loads the shadow settings. Requests and pixels follow the live settings, which are replaced by the shadow copy only when `vsync` is high at a clock edge. A write made during a scan does not alter that scan, and without a later `vsync` it starts nothing.
- R3: In progressive mode, line n is read from base + n*stride. A line of W pixels of B bytes takes ceil(W*B/4) requests at consecutive addresses 4 apart. Base and stride are multiples of 4.
- R4: When `cfg_ilace`=1, line n is read from base + (2n + f)*stride, where f is `field_odd` sampled together with `vsync`.
- R5: Packing code 0 is 16-bit 5:6:5 in little-endian halfwords, with the earlier pixel in the lower halfword. Red is bits 15:11, green 10:5 and blue 4:0. Each channel is widened by appending its own top bits below it.
- R6: Packing code 1 is 3 bytes per pixel in byte order B, G, R at ascending addresses. A pixel may span two words, and the bytes left over at the end of a line are dropped.
- R7: Packing codes 2 and 3 are 4 bytes per pixel, with B, G, R in bytes 0 to 2. Byte 3 does not affect the output.
- R8: Y = ((66R+129G+25B+128)>>8)+16, Cb = ((-38R-74G+112B+128)>>8)+128 and Cr = ((112R-94G-18B+128)>>8)+128, with floor shifts. Y is clamped to 16..235, and Cb and Cr to 16..240.
- R9: While `pix_valid` is high and `pix_ready` is low, `pix_valid` stays high and all pixel fields hold their values.
- R10: `pix_sof` marks only the first pixel of a scan, and `pix_eol` marks every W-th pixel. After exactly W*lines pixels, no further requests or pixels occur until the next `vsync`.
- R11: If the committed plane has enable=0, width=0 or lines=0, no requests and no pixels are produced.
- R12: At most one request is outstanding. Once raised, `mem_req_valid` and `mem_req_addr` hold until `mem_req_ready`, unless a `vsync` restarts the scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vsync | input | 1 | Commit pulse; starts a scan |
| field_odd | input | 1 | Field select, sampled with vsync |
| cfg_wr | input | 1 | Load the shadow settings |
| cfg_en | input | 1 | Plane enable |
| cfg_fmt | input | 2 | Packing code |
| cfg_ilace | input | 1 | Interlaced line walking |
| cfg_base | input | AW | Byte address of the plane |
| cfg_stride | input | SW | Bytes between lines |
| cfg_width | input | XW | Pixels per line |
| cfg_lines | input | YW | Lines per scan |
| mem_req_valid | output | 1 | Word request |
| mem_req_ready | input | 1 | Request accepted |
| mem_req_addr | output | AW | Word byte address |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 32 | Read word |
| pix_valid | output | 1 | Pixel available |
| pix_ready | input | 1 | Pixel taken |
| pix_y | output | 8 | Luma |
| pix_cb | output | 8 | Blue difference |
| pix_cr | output | 8 | Red difference |
| pix_sof | output | 1 | First pixel of scan |
| pix_eol | output | 1 | Last pixel of line |

## Verification
The hardest case to reach is a settings write that lands while a scan is half done. The staging buffer must also be holding a partial 3-byte pixel at that moment, with memory and the pixel sink both stalling. The stimulus starts one scan, waits a few dozen cycles, and then rewrites every field with `cfg_wr`. It checks that the rest of the scan still follows the old settings and that nothing starts before the next sync. Random ready patterns on both sides force word arrivals and pixel removals into every relative order, and the odd widths used leave partial words at line ends.

// File: rtl/osd_scan_pkg.sv
package osd_scan_pkg;

    typedef enum logic [1:0] {
        PK_RGB565   = 2'd0,
        PK_RGB888   = 2'd1,
        PK_XRGB     = 2'd2,
        PK_XRGB_ALT = 2'd3
    } pack_e;

    localparam int WORD_BITS  = 32;
    localparam int WORD_BYTES = WORD_BITS / 8;
    localparam int BUF_BYTES  = 2 * WORD_BYTES;
    localparam int BUF_BITS   = BUF_BYTES * 8;
    localparam int CNT_W      = $clog2(BUF_BYTES + 1);

    // bytes taken by one pixel of the given packing
    function automatic logic [2:0] pix_bytes(input pack_e f);
        case (f)
            PK_RGB565: return 3'd2;
            PK_RGB888: return 3'd3;
            default:   return 3'd4;
        endcase
    endfunction

    function automatic logic [7:0] clamp8(input logic signed [19:0] v,
                                          input logic [7:0] lo,
                                          input logic [7:0] hi);
        if (v < $signed({12'd0, lo}))      return lo;
        else if (v > $signed({12'd0, hi})) return hi;
        else                               return v[7:0];
    endfunction

endpackage

// File: rtl/osd_line_walker.sv
module osd_line_walker
    import osd_scan_pkg::*;
#(
    parameter int AW = 32,
    parameter int SW = 16,
    parameter int XW = 12,
    parameter int YW = 11
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 restart,
    input  logic                 en,
    input  pack_e                fmt,
    input  logic                 ilace,
    input  logic                 field,
    input  logic [AW-1:0]        base,
    input  logic [SW-1:0]        stride,
    input  logic [XW-1:0]        width,
    input  logic [YW-1:0]        lines,
    input  logic                 room,
    input  logic                 line_done,
    output logic                 req_valid,
    input  logic                 req_ready,
    output logic [AW-1:0]        req_addr,
    input  logic                 rsp_valid,
    input  logic [WORD_BITS-1:0] rsp_data,
    output logic                 wr_valid,
    output logic [WORD_BITS-1:0] wr_data
);
    localparam int BW = XW + 3;

    typedef enum logic {WK_IDLE, WK_LINE} wk_st_e;

    typedef struct packed {
        wk_st_e        st;
        logic [AW-1:0] line_addr;
        logic [AW-1:0] word_addr;
        logic [YW-1:0] line_idx;
        logic [BW-1:0] words_left;
        logic          inflight;
        logic          stale;
    } wk_t;

    wk_t q, d;

    logic [BW-1:0] line_bytes;
    logic [BW-1:0] line_words;
    logic [AW-1:0] step;
    logic [AW-1:0] first_addr;
    logic          hs;
    logic          can_start;

    always_comb begin
        line_bytes = BW'(width) * BW'(pix_bytes(fmt));
        line_words = (line_bytes + BW'(3)) >> 2;
        step       = ilace ? (AW'(stride) << 1) : AW'(stride);
        first_addr = base + ((ilace && field) ? AW'(stride) : '0);
        can_start  = en && (width != '0) && (lines != '0);

        req_valid = (q.st == WK_LINE) && (q.words_left != '0) && !q.inflight && room;
        req_addr  = q.word_addr;
        hs        = req_valid && req_ready;
        wr_valid  = rsp_valid && !q.stale;
        wr_data   = rsp_data;

        d = q;
        if (rsp_valid) begin
            d.inflight = 1'b0;
            d.stale    = 1'b0;
        end
        if (hs) begin
            d.inflight   = 1'b1;
            d.words_left = q.words_left - 1'b1;
            d.word_addr  = q.word_addr + AW'(WORD_BYTES);
        end
        if (line_done && q.st == WK_LINE) begin
            if (q.line_idx == lines - 1'b1) begin
                d.st = WK_IDLE;
            end else begin
                d.line_idx   = q.line_idx + 1'b1;
                d.line_addr  = q.line_addr + step;
                d.word_addr  = q.line_addr + step;
                d.words_left = line_words;
            end
        end
        if (restart) begin
            // a word still owed by memory belongs to the old scan
            d.stale      = d.inflight;
            d.st         = can_start ? WK_LINE : WK_IDLE;
            d.line_idx   = '0;
            d.line_addr  = first_addr;
            d.word_addr  = first_addr;
            d.words_left = line_words;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R12: a raised request holds until taken
    assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready && !restart) |=> (req_valid && $stable(req_addr)));

    // R12: no new request while a response is being delivered
    assert_one_out_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_valid);

endmodule

// File: rtl/osd_pix_unpack.sv
module osd_pix_unpack
    import osd_scan_pkg::*;
#(
    parameter int XW = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 restart,
    input  pack_e                fmt,
    input  logic [XW-1:0]        width,
    input  logic                 wr_valid,
    input  logic [WORD_BITS-1:0] wr_data,
    output logic                 room,
    output logic                 px_valid,
    input  logic                 px_ready,
    output logic [23:0]          px_rgb,
    output logic                 px_sof,
    output logic                 px_eol,
    output logic                 line_done
);
    typedef struct packed {
        logic [BUF_BITS-1:0] data;
        logic [CNT_W-1:0]    cnt;
        logic [XW-1:0]       idx;
        logic                sof;
    } up_t;

    up_t q, d;

    logic [2:0]          bpp;
    logic [2:0]          used;
    logic [CNT_W-1:0]    keep;
    logic [BUF_BITS-1:0] kept;
    logic [15:0]         hw;
    logic                fire;

    always_comb begin
        bpp       = pix_bytes(fmt);
        px_valid  = q.cnt >= CNT_W'(bpp);
        px_eol    = q.idx == width - 1'b1;
        px_sof    = q.sof;
        fire      = px_valid && px_ready;
        line_done = fire && px_eol;
        room      = q.cnt <= CNT_W'(WORD_BYTES);

        hw = q.data[15:0];
        case (fmt)
            PK_RGB565: px_rgb = {hw[15:11], hw[15:13], hw[10:5], hw[10:9], hw[4:0], hw[4:2]};
            default:   px_rgb = {q.data[23:16], q.data[15:8], q.data[7:0]};
        endcase

        used = fire ? bpp : 3'd0;
        keep = line_done ? '0 : q.cnt - CNT_W'(used);
        kept = line_done ? '0 : (q.data >> {used, 3'b000});

        d = q;
        d.data = kept;
        d.cnt  = keep;
        if (wr_valid) begin
            d.data = kept | ({{(BUF_BITS-WORD_BITS){1'b0}}, wr_data} << {keep, 3'b000});
            d.cnt  = keep + CNT_W'(WORD_BYTES);
        end
        if (fire) begin
            d.sof = 1'b0;
            d.idx = line_done ? '0 : q.idx + 1'b1;
        end
        if (restart) begin
            d.data = '0;
            d.cnt  = '0;
            d.idx  = '0;
            d.sof  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R6: a word only arrives when the staging buffer can hold it
    assert_buf_fit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (q.cnt <= CNT_W'(WORD_BYTES)));

endmodule

// File: rtl/osd_ycc_stage.sv
module osd_ycc_stage
    import osd_scan_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [23:0] in_rgb,
    input  logic        in_sof,
    input  logic        in_eol,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [7:0]  out_y,
    output logic [7:0]  out_cb,
    output logic [7:0]  out_cr,
    output logic        out_sof,
    output logic        out_eol
);
    typedef struct packed {
        logic       valid;
        logic [7:0] y;
        logic [7:0] cb;
        logic [7:0] cr;
        logic       sof;
        logic       eol;
    } yc_t;

    yc_t q, d;

    logic signed [19:0] rs, gs, bs, ys, cbs, crs;

    always_comb begin
        rs  = $signed({12'd0, in_rgb[23:16]});
        gs  = $signed({12'd0, in_rgb[15:8]});
        bs  = $signed({12'd0, in_rgb[7:0]});
        ys  = ((20'sd66 * rs + 20'sd129 * gs + 20'sd25 * bs + 20'sd128) >>> 8) + 20'sd16;
        cbs = ((20'sd112 * bs - 20'sd38 * rs - 20'sd74 * gs + 20'sd128) >>> 8) + 20'sd128;
        crs = ((20'sd112 * rs - 20'sd94 * gs - 20'sd18 * bs + 20'sd128) >>> 8) + 20'sd128;

        in_ready = !q.valid || out_ready;

        d = q;
        if (in_ready) begin
            d.valid = in_valid;
            if (in_valid) begin
                d.y   = clamp8(ys, 8'd16, 8'd235);
                d.cb  = clamp8(cbs, 8'd16, 8'd240);
                d.cr  = clamp8(crs, 8'd16, 8'd240);
                d.sof = in_sof;
                d.eol = in_eol;
            end
        end

        out_valid = q.valid;
        out_y     = q.y;
        out_cb    = q.cb;
        out_cr    = q.cr;
        out_sof   = q.sof;
        out_eol   = q.eol;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R9: a stalled pixel is held unchanged
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable({out_y, out_cb, out_cr, out_sof, out_eol})));

    // R8: presented values stay in studio range
    assert_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_y >= 8'd16 && out_y <= 8'd235 &&
                       out_cb >= 8'd16 && out_cb <= 8'd240 &&
                       out_cr >= 8'd16 && out_cr <= 8'd240));

endmodule

// File: rtl/osd_scan_fmt.sv
module osd_scan_fmt
    import osd_scan_pkg::*;
#(
    parameter int AW = 32,
    parameter int SW = 16,
    parameter int XW = 12,
    parameter int YW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vsync,
    input  logic          field_odd,
    input  logic          cfg_wr,
    input  logic          cfg_en,
    input  logic [1:0]    cfg_fmt,
    input  logic          cfg_ilace,
    input  logic [AW-1:0] cfg_base,
    input  logic [SW-1:0] cfg_stride,
    input  logic [XW-1:0] cfg_width,
    input  logic [YW-1:0] cfg_lines,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic [AW-1:0] mem_req_addr,
    input  logic          mem_rsp_valid,
    input  logic [31:0]   mem_rsp_data,
    output logic          pix_valid,
    input  logic          pix_ready,
    output logic [7:0]    pix_y,
    output logic [7:0]    pix_cb,
    output logic [7:0]    pix_cr,
    output logic          pix_sof,
    output logic          pix_eol
);
    typedef struct packed {
        logic          en;
        pack_e         fmt;
        logic          ilace;
        logic [AW-1:0] base;
        logic [SW-1:0] stride;
        logic [XW-1:0] width;
        logic [YW-1:0] lines;
    } plane_t;

    typedef struct packed {
        plane_t shadow;
        plane_t live;
        logic   field;
        logic   go;
    } top_t;

    top_t q, d;

    always_comb begin
        d    = q;
        d.go = vsync;
        if (cfg_wr) begin
            d.shadow.en     = cfg_en;
            d.shadow.fmt    = pack_e'(cfg_fmt);
            d.shadow.ilace  = cfg_ilace;
            d.shadow.base   = cfg_base;
            d.shadow.stride = cfg_stride;
            d.shadow.width  = cfg_width;
            d.shadow.lines  = cfg_lines;
        end
        if (vsync) begin
            d.live  = q.shadow;
            d.field = field_odd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    logic        room, line_done, wr_valid;
    logic [31:0] wr_data;
    logic        px_valid, px_ready, px_sof, px_eol;
    logic [23:0] px_rgb;

    osd_line_walker #(.AW(AW), .SW(SW), .XW(XW), .YW(YW)) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (q.go),
        .en        (q.live.en),
        .fmt       (q.live.fmt),
        .ilace     (q.live.ilace),
        .field     (q.field),
        .base      (q.live.base),
        .stride    (q.live.stride),
        .width     (q.live.width),
        .lines     (q.live.lines),
        .room      (room),
        .line_done (line_done),
        .req_valid (mem_req_valid),
        .req_ready (mem_req_ready),
        .req_addr  (mem_req_addr),
        .rsp_valid (mem_rsp_valid),
        .rsp_data  (mem_rsp_data),
        .wr_valid  (wr_valid),
        .wr_data   (wr_data)
    );

    osd_pix_unpack #(.XW(XW)) u_unpack (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (q.go),
        .fmt       (q.live.fmt),
        .width     (q.live.width),
        .wr_valid  (wr_valid),
        .wr_data   (wr_data),
        .room      (room),
        .px_valid  (px_valid),
        .px_ready  (px_ready),
        .px_rgb    (px_rgb),
        .px_sof    (px_sof),
        .px_eol    (px_eol),
        .line_done (line_done)
    );

    osd_ycc_stage u_ycc (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (px_valid),
        .in_ready  (px_ready),
        .in_rgb    (px_rgb),
        .in_sof    (px_sof),
        .in_eol    (px_eol),
        .out_valid (pix_valid),
        .out_ready (pix_ready),
        .out_y     (pix_y),
        .out_cb    (pix_cb),
        .out_cr    (pix_cr),
        .out_sof   (pix_sof),
        .out_eol   (pix_eol)
    );

    // R2: live settings change only on a sync pulse
    assert_shadow_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !vsync |=> $stable(q.live));

    // R11: a disabled live plane issues no requests once restarted
    assert_off_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.live.en && !q.go) |-> !mem_req_valid);

endmodule

// File: tb/sim_osd_scan_fmt.sv
`timescale 1ns/1ps
module sim_osd_scan_fmt;
    localparam int AW = 32, SW = 16, XW = 12, YW = 11;

    logic clk = 1'b0, rst_n = 1'b0;
    logic vsync = 0, field_odd = 0, cfg_wr = 0, cfg_en = 0, cfg_ilace = 0;
    logic [1:0] cfg_fmt = 0;
    logic [AW-1:0] cfg_base = 0;
    logic [SW-1:0] cfg_stride = 0;
    logic [XW-1:0] cfg_width = 0;
    logic [YW-1:0] cfg_lines = 0;
    logic mem_req_valid, mem_req_ready = 0, mem_rsp_valid = 0;
    logic [AW-1:0] mem_req_addr;
    logic [31:0] mem_rsp_data = 0;
    logic pix_valid, pix_ready = 0, pix_sof, pix_eol;
    logic [7:0] pix_y, pix_cb, pix_cr;

    always #10 clk = ~clk;

    osd_scan_fmt #(.AW(AW), .SW(SW), .XW(XW), .YW(YW)) u0 (.*);

    int n_chk = 0, n_bad = 0;
    int n_req_seen = 0, n_pix_seen = 0;
    string tag = "R1";
    logic [25:0] exp_pix[$];
    logic [31:0] exp_addr[$];
    bit ready_rand = 1;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        if (a[31:4] == 28'h0001000) begin
            case (a[3:2])
                2'd0:    return 32'h00FFFFFF;
                2'd1:    return 32'hAA000000;
                2'd2:    return 32'h00FF0000;
                default: return 32'h550000FF;
            endcase
        end
        return (a * 32'h9E3779B1) ^ {a[15:0], a[31:16]} ^ 32'h5A5A1234;
    endfunction

    function automatic logic [7:0] mbyte(input logic [31:0] a);
        logic [31:0] w;
        w = mem_word({a[31:2], 2'b00}) >> (8 * a[1:0]);
        return w[7:0];
    endfunction

    function automatic int clampi(input int v, input int lo, input int hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction

    // expected pixel from the conversion formula (R8)
    function automatic logic [23:0] to_ycc(input int r, input int g, input int b);
        int y, cb, cr;
        y  = ((66*r + 129*g + 25*b + 128) >>> 8) + 16;
        cb = ((-38*r - 74*g + 112*b + 128) >>> 8) + 128;
        cr = ((112*r - 94*g - 18*b + 128) >>> 8) + 128;
        return {8'(clampi(y, 16, 235)), 8'(clampi(cb, 16, 240)), 8'(clampi(cr, 16, 240))};
    endfunction

    task automatic push_frame(input int fmt, input bit il, input bit fld, input int base,
                              input int stride, input int width, input int lines);
        int bpp, nw, lad, a, r, g, b;
        logic [15:0] h;
        bpp = (fmt == 0) ? 2 : ((fmt == 1) ? 3 : 4);
        nw  = (width * bpp + 3) / 4;
        for (int l = 0; l < lines; l++) begin
            lad = il ? base + (2*l + int'(fld)) * stride : base + l * stride;
            for (int k = 0; k < nw; k++) exp_addr.push_back(32'(lad + 4*k));
            for (int p = 0; p < width; p++) begin
                a = lad + p * bpp;
                if (fmt == 0) begin
                    h = {mbyte(32'(a + 1)), mbyte(32'(a))};
                    r = {h[15:11], h[15:13]};
                    g = {h[10:5], h[10:9]};
                    b = {h[4:0], h[4:2]};
                end else begin
                    b = mbyte(32'(a));
                    g = mbyte(32'(a + 1));
                    r = mbyte(32'(a + 2));
                end
                exp_pix.push_back({to_ycc(r, g, b), (l == 0 && p == 0), (p == width - 1)});
            end
        end
    endtask

    task automatic set_cfg(input bit en, input int fmt, input bit il, input int base,
                           input int stride, input int width, input int lines);
        @(posedge clk); #1;
        cfg_wr = 1; cfg_en = en; cfg_fmt = 2'(fmt); cfg_ilace = il;
        cfg_base = AW'(base); cfg_stride = SW'(stride);
        cfg_width = XW'(width); cfg_lines = YW'(lines);
        @(posedge clk); #1;
        cfg_wr = 0;
    endtask

    task automatic pulse_vs(input bit fld);
        @(posedge clk); #1;
        vsync = 1; field_odd = fld;
        @(posedge clk); #1;
        vsync = 0;
    endtask

    task automatic drain();
        int t = 0;
        while ((exp_pix.size() != 0 || exp_addr.size() != 0) && t < 20000) begin
            @(posedge clk); t++;
        end
        check(t < 20000, tag, "scan completed", exp_pix.size(), 0);
        repeat (30) @(posedge clk);
    endtask

    // memory model and input drivers, changed just after each edge
    bit acc_next = 0;
    logic [31:0] acc_addr, rsp_addr;
    int rsp_cnt = 0;
    bit rq_pend = 0, px_pend = 0;
    logic [31:0] rq_held;
    logic [25:0] px_held;

    always @(posedge clk) begin
        #1;
        mem_rsp_valid = 0;
        if (rsp_cnt > 0) begin
            rsp_cnt--;
            if (rsp_cnt == 0) begin
                mem_rsp_valid = 1;
                mem_rsp_data  = mem_word(rsp_addr);
            end
        end
        if (acc_next) begin
            acc_next = 0;
            n_req_seen++;
            // R3 / R4 address order, per the running test tag
            if (exp_addr.size() == 0) check(0, tag, "unexpected request", acc_addr, 0);
            else begin
                logic [31:0] e;
                e = exp_addr.pop_front();
                check(acc_addr == e, tag, "request address", acc_addr, e);
            end
            rsp_addr = acc_addr;
            rsp_cnt  = 1 + int'($urandom % 3);
        end
        mem_req_ready = ($urandom % 4) != 0;
        pix_ready     = ready_rand ? (($urandom % 3) != 0) : 1'b1;
    end

    // monitor: samples away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (rq_pend)
                check(mem_req_valid && mem_req_addr == rq_held, "R12", "request held", mem_req_addr, rq_held);
            rq_pend = mem_req_valid && !mem_req_ready && !vsync;
            rq_held = mem_req_addr;
            if (mem_req_valid && (rsp_cnt > 0 || mem_rsp_valid))
                check(0, "R12", "second request outstanding", 1, 0);
            if (mem_req_valid && mem_req_ready) begin
                acc_next = 1;
                acc_addr = mem_req_addr;
            end

            if (px_pend)
                check(pix_valid && {pix_y, pix_cb, pix_cr, pix_sof, pix_eol} == px_held, "R9",
                      "stalled pixel held", {pix_y, pix_cb, pix_cr, pix_sof, pix_eol}, px_held);
            px_pend = pix_valid && !pix_ready;
            px_held = {pix_y, pix_cb, pix_cr, pix_sof, pix_eol};
            if (pix_valid && pix_ready) begin
                logic [25:0] got, e;
                n_pix_seen++;
                got = {pix_y, pix_cb, pix_cr, pix_sof, pix_eol};
                if (exp_pix.size() == 0) check(0, tag, "unexpected pixel", got, 0);
                else begin
                    e = exp_pix.pop_front();
                    check(got == e, tag, "pixel y/cb/cr/sof/eol", got, e);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        int r0, p0;
        repeat (3) @(posedge clk);
        #1;
        check(!mem_req_valid, "R1", "req during reset", mem_req_valid, 0);
        check(!pix_valid, "R1", "pix during reset", pix_valid, 0);
        rst_n = 1;
        repeat (3) @(posedge clk);
        #1;
        check(!mem_req_valid, "R1", "req after reset", mem_req_valid, 0);
        check(!pix_valid, "R1", "pix after reset", pix_valid, 0);

        // R11: disabled plane, then enabled but zero width
        tag = "R11";
        set_cfg(0, 2, 0, 32'h100, 16, 4, 2);
        pulse_vs(0);
        repeat (40) @(posedge clk);
        check(n_req_seen == 0 && n_pix_seen == 0, "R11", "disabled plane quiet", n_req_seen + n_pix_seen, 0);
        set_cfg(1, 2, 0, 32'h100, 16, 0, 2);
        pulse_vs(0);
        repeat (40) @(posedge clk);
        check(n_req_seen == 0 && n_pix_seen == 0, "R11", "zero width quiet", n_req_seen + n_pix_seen, 0);

        // R5: 5:6:5 packing, odd width leaves a half word per line
        tag = "R5";
        push_frame(0, 0, 0, 32'h100, 64, 7, 3);
        set_cfg(1, 0, 0, 32'h100, 64, 7, 3);
        pulse_vs(0);
        drain();

        // R6: 3-byte pixels spanning words
        tag = "R6";
        push_frame(1, 0, 0, 32'h2000, 48, 5, 3);
        set_cfg(1, 1, 0, 32'h2000, 48, 5, 3);
        pulse_vs(0);
        drain();

        // R7 and R8: pad byte set, saturated colours, stride zero
        tag = "R7";
        push_frame(2, 0, 0, 32'h10000, 0, 4, 2);
        set_cfg(1, 2, 0, 32'h10000, 0, 4, 2);
        pulse_vs(0);
        drain();
        tag = "R8";
        push_frame(3, 0, 0, 32'h10000, 0, 4, 1);
        set_cfg(1, 3, 0, 32'h10000, 0, 4, 1);
        pulse_vs(1);
        drain();
        check(to_ycc(255, 255, 255) == 24'hEB8080, "R8", "white reference", to_ycc(255, 255, 255), 24'hEB8080);

        // R3: progressive walk at a wide stride
        tag = "R3";
        push_frame(2, 0, 0, 32'h6000, 100, 10, 3);
        set_cfg(1, 2, 0, 32'h6000, 100, 10, 3);
        pulse_vs(0);
        drain();

        // R4: interlaced odd then even field
        tag = "R4";
        push_frame(2, 1, 1, 32'h3000, 32, 3, 3);
        set_cfg(1, 2, 1, 32'h3000, 32, 3, 3);
        pulse_vs(1);
        drain();
        push_frame(0, 1, 0, 32'h3000, 32, 3, 3);
        set_cfg(1, 0, 1, 32'h3000, 32, 3, 3);
        pulse_vs(0);
        drain();

        // R2: rewrite the settings in the middle of a scan
        tag = "R2";
        push_frame(1, 0, 0, 32'h4000, 40, 9, 4);
        set_cfg(1, 1, 0, 32'h4000, 40, 9, 4);
        pulse_vs(0);
        repeat (25) @(posedge clk);
        set_cfg(1, 0, 1, 32'h5000, 24, 6, 2);
        drain();
        r0 = n_req_seen; p0 = n_pix_seen;
        repeat (60) @(posedge clk);
        check(n_req_seen == r0 && n_pix_seen == p0, "R2", "no start without sync", n_pix_seen - p0, 0);
        push_frame(0, 1, 1, 32'h5000, 24, 6, 2);
        pulse_vs(1);
        drain();

        // R10: longer scan with a sink that never stalls, then idle
        tag = "R10";
        ready_rand = 0;
        push_frame(0, 0, 0, 32'h7000, 36, 16, 5);
        set_cfg(1, 0, 0, 32'h7000, 36, 16, 5);
        pulse_vs(0);
        drain();
        r0 = n_req_seen; p0 = n_pix_seen;
        repeat (50) @(posedge clk);
        check(n_req_seen == r0 && n_pix_seen == p0, "R10", "idle after last line", n_pix_seen - p0, 0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule